// File: doc/BRIEF.md
# Cascadable token-chain FIFO

This block builds one deep first-in/first-out buffer out of a ring of identical storage slices. Each slice owns a small local array. All slices share one write strobe, one read strobe and one write data bus. Two ownership tokens travel around the ring: a write token and a read token. Only the slice that holds the write token stores incoming words. Only the slice that holds the read token presents a word on the read data bus.

When a slice fills its last physical location, it hands the write token on by raising a one-cycle pulse on its write expansion output. That output feeds the write expansion input of the next slice. Reading the last location hands the read token on in the same way, over a second, separate expansion line. The last slice feeds the first, so the chain closes into a ring.

After reset, the slice whose first-load input is driven low holds both tokens. Every pointer sits at location zero and every slice reports empty. Each slice produces active-low full and empty flags. The top level merges them into one composite pair, and a composite flag is asserted only when every slice asserts it. Read data is shown ahead: whenever the buffer is not empty, the oldest word is already on the read data bus, and a read strobe removes it.

Top module: `dx_chain_fifo`

## Requirements
- R1: A synchronous active-high reset leaves the buffer empty: `empty_n` reads 0, `full_n` reads 1, all stored words are dropped, and slice 0 (first-load input low) holds both tokens.
- R2: Words leave in the order they were written, across slice boundaries and across wrap-around of the ring. While `empty_n` is 1, `rd_data` shows the oldest stored word.
- R3: A slice that writes its last physical location pulses its write expansion output for that cycle only. From the next cycle, the next slice in the ring holds the write token. At all times exactly one slice holds the write token.
- R4: A slice that reads its last physical location pulses its read expansion output for that cycle only. From the next cycle, the next slice in the ring holds the read token. At all times exactly one slice holds the read token.
- R5: `full_n` is 0 exactly when N_SLICES*DEPTH words are stored. A write strobe while `full_n` is 0 stores nothing.
- R6: `empty_n` is 0 exactly when no word is stored. A read strobe while `empty_n` is 0 removes nothing.
- R7: In a cycle with both strobes high, the read takes effect if the buffer was not empty at the start of the cycle. The write takes effect if the buffer was not full at the start of the cycle.
- R8: A word written into an empty buffer appears on `rd_data`, with `empty_n` at 1, after one clock edge.
- R9: The composite `full_n` and `empty_n` are the OR of the active-low per-slice flags, so each is low only when every slice reports that condition.
- R10: Only the slice holding the read token enables its output, and at most one slice enables its output in any cycle.
- R11: A slice without the write token never raises its write expansion pulse. A slice without the read token never raises its read expansion pulse. Such a slice ignores the shared strobes and leaves its pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shared write strobe, one word per cycle while high |
| wr_data | input | WIDTH | Shared write data bus |
| rd_en | input | 1 | Shared read strobe, removes the shown word |
| rd_data | output | WIDTH | Oldest stored word, from the read-token slice |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |

## Verification
Every result of this block is due exactly one rising edge after the strobes that cause it. That covers the occupancy flags, the shown-ahead read word and the token handover to the next slice. No result takes longer, because the expansion pulse reaches the next slice's token register in the same cycle. The bench drives strobes on the falling edge and updates its queue model on the rising edge. It compares `rd_data`, `full_n` and `empty_n` against the model at the following falling edge, so each check lands one edge after the stimulus. The stimulus crosses every slice boundary, wraps the ring several times, drives strobes against a full and an empty buffer, and resets in the middle of traffic.

// File: rtl/dx_pkg.sv
package dx_pkg;

    // Pair of one-cycle token-handover pulses on the expansion lines
    typedef struct packed {
        logic wr;
        logic rd;
    } dx_xpulse_t;

    // Strobes that actually take effect inside one slice
    typedef struct packed {
        logic do_wr;
        logic do_rd;
    } dx_fire_t;

    // Index of the ring neighbour that feeds slice i
    function automatic int dx_prev(input int i, input int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

endpackage

// File: rtl/dx_ptr.sv
module dx_ptr #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr,
    output logic             at_last
);
    assign at_last = (ptr == PTR_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= at_last ? '0 : ptr + PTR_W'(1);
        end
    end
endmodule

// File: rtl/dx_token_cell.sv
module dx_token_cell (
    input  logic clk,
    input  logic rst,
    input  logic first_load_n,
    input  logic take,
    input  logic fire,
    input  logic at_last,
    output logic hold,
    output logic pass
);
    // Handover happens on the strobe that touches the last location
    assign pass = fire & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= ~first_load_n;
        end else if (take) begin
            hold <= 1'b1;
        end else if (pass) begin
            hold <= 1'b0;
        end
    end
endmodule

// File: rtl/dx_slice_ram.sv
module dx_slice_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dx_slice.sv
module dx_slice
    import dx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_load_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  dx_xpulse_t       xin,
    output dx_xpulse_t       xout,
    output logic [WIDTH-1:0] q,
    output logic             q_oe,
    output logic             full_n,
    output logic             empty_n,
    output logic             wtok,
    output logic             rtok
);
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] wptr, rptr;
    logic             w_last, r_last;
    logic             is_full, is_empty;
    dx_fire_t         fire;

    assign is_full  = (count == CNT_W'(DEPTH));
    assign is_empty = (count == '0);
    assign full_n   = ~is_full;
    assign empty_n  = ~is_empty;

    assign fire.do_wr = wr_en & wtok & ~is_full;
    assign fire.do_rd = rd_en & rtok & ~is_empty;

    dx_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst(rst), .inc(fire.do_wr), .ptr(wptr), .at_last(w_last)
    );
    dx_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst(rst), .inc(fire.do_rd), .ptr(rptr), .at_last(r_last)
    );

    dx_token_cell u_wtok (
        .clk(clk), .rst(rst), .first_load_n(first_load_n), .take(xin.wr),
        .fire(fire.do_wr), .at_last(w_last), .hold(wtok), .pass(xout.wr)
    );
    dx_token_cell u_rtok (
        .clk(clk), .rst(rst), .first_load_n(first_load_n), .take(xin.rd),
        .fire(fire.do_rd), .at_last(r_last), .hold(rtok), .pass(xout.rd)
    );

    dx_slice_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk(clk), .we(fire.do_wr), .waddr(wptr), .wdata(wr_data),
        .raddr(rptr), .rdata(q)
    );

    assign q_oe = rtok & ~is_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({fire.do_wr, fire.do_rd})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dx_chain_fifo.sv
module dx_chain_fifo
    import dx_pkg::*;
#(
    parameter int N_SLICES = 4,
    parameter int DEPTH    = 8,
    parameter int WIDTH    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full_n,
    output logic             empty_n
);
    dx_xpulse_t       xo [N_SLICES];
    logic [WIDTH-1:0] q  [N_SLICES];
    logic [N_SLICES-1:0] oe_vec, wtok_vec, rtok_vec, fn_vec, en_vec;
    logic [N_SLICES-1:0] wxo_vec, rxo_vec;

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        localparam int PREV = dx_prev(i, N_SLICES);
        dx_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slice (
            .clk          (clk),
            .rst          (rst),
            .first_load_n ((i == 0) ? 1'b0 : 1'b1),
            .wr_en        (wr_en),
            .wr_data      (wr_data),
            .rd_en        (rd_en),
            .xin          (xo[PREV]),
            .xout         (xo[i]),
            .q            (q[i]),
            .q_oe         (oe_vec[i]),
            .full_n       (fn_vec[i]),
            .empty_n      (en_vec[i]),
            .wtok         (wtok_vec[i]),
            .rtok         (rtok_vec[i])
        );
        assign wxo_vec[i] = xo[i].wr;
        assign rxo_vec[i] = xo[i].rd;
    end

    // Composite active-low flags: low only when every slice is low
    assign full_n  = |fn_vec;
    assign empty_n = |en_vec;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_SLICES; i++) begin
            if (oe_vec[i]) begin
                rd_data = rd_data | q[i];
            end
        end
    end
endmodule

// File: rtl/dx_chain_fifo_chk.sv
module dx_chain_fifo_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         rd_en,
    input logic         full_n,
    input logic         empty_n,
    input logic [N-1:0] wtok,
    input logic [N-1:0] rtok,
    input logic [N-1:0] oe,
    input logic [N-1:0] wxo,
    input logic [N-1:0] rxo
);
    a_r1_reset_flags: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n));
    a_r1_reset_tokens: assert property (@(posedge clk)
        rst |=> (wtok[0] && rtok[0]));
    a_r3_one_wtok: assert property (@(posedge clk) disable iff (rst)
        $onehot(wtok));
    a_r4_one_rtok: assert property (@(posedge clk) disable iff (rst)
        $onehot(rtok));
    a_r10_one_oe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oe));
    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !rd_en) |=> !full_n);
    a_r6_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && !wr_en) |=> !empty_n);

    for (genvar i = 0; i < N; i++) begin : g_ring
        localparam int NXT = (i + 1) % N;
        a_r3_wpass: assert property (@(posedge clk) disable iff (rst)
            wxo[i] |=> wtok[NXT]);
        a_r4_rpass: assert property (@(posedge clk) disable iff (rst)
            rxo[i] |=> rtok[NXT]);
        a_r11_no_wpulse: assert property (@(posedge clk) disable iff (rst)
            !wtok[i] |-> !wxo[i]);
        a_r11_no_rpulse: assert property (@(posedge clk) disable iff (rst)
            !rtok[i] |-> !rxo[i]);
        a_r10_oe_owner: assert property (@(posedge clk) disable iff (rst)
            oe[i] |-> rtok[i]);
    end
endmodule

bind dx_chain_fifo dx_chain_fifo_chk #(.N(N_SLICES)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .full_n(full_n), .empty_n(empty_n),
    .wtok(wtok_vec), .rtok(rtok_vec), .oe(oe_vec),
    .wxo(wxo_vec), .rxo(rxo_vec)
);

// File: tb/dx_chain_fifo_bench.sv
module dx_chain_fifo_bench;
    localparam int N     = 4;
    localparam int DEPTH = 8;
    localparam int WIDTH = 9;
    localparam int CAP   = N * DEPTH;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             full_n, empty_n;

    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    string cur_req = "R1";
    logic [WIDTH-1:0] mq[$];
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    dx_chain_fifo #(.N_SLICES(N), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dx_chain_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n)
    );

    // Behavioural model: a plain bounded queue
    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
        end else begin
            bit acc_r, acc_w;
            acc_r = rd_en && (mq.size() > 0);
            acc_w = wr_en && (mq.size() < CAP);
            if (acc_r) void'(mq.pop_front());
            if (acc_w) mq.push_back(wr_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 200000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // Compare all outputs against the model, one edge after the stimulus
    task automatic compare_all();
        chk(empty_n == (mq.size() != 0), cur_req, "empty_n",
            int'(empty_n), int'(mq.size() != 0));
        chk(full_n == (mq.size() != CAP), cur_req, "full_n",
            int'(full_n), int'(mq.size() != CAP));
        if (mq.size() > 0)
            chk(rd_data == mq[0], cur_req, "rd_data", int'(rd_data), int'(mq[0]));
    endtask

    task automatic step(input bit w, input bit r, input logic [WIDTH-1:0] d);
        @(negedge clk);
        compare_all();
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(empty_n == 1'b0, "R1", "empty_n after reset", int'(empty_n), 0);
        chk(full_n == 1'b1, "R1", "full_n after reset", int'(full_n), 1);

        // R8: one write into empty is visible after one edge
        cur_req = "R8";
        step(1'b1, 1'b0, 9'h1A5);
        step(1'b0, 1'b0, '0);
        chk(rd_data == 9'h1A5, "R8", "first word shown", int'(rd_data), 'h1A5);
        step(1'b0, 1'b1, '0);

        // R3/R5: fill across every slice boundary, then push against full
        cur_req = "R3";
        for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, WIDTH'(i * 7 + 3));
        step(1'b0, 1'b0, '0);
        cur_req = "R5";
        chk(full_n == 1'b0, "R5", "full after capacity", int'(full_n), 0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 9'h1FF);

        // R7: read and write together while full, only the read lands
        cur_req = "R7";
        step(1'b1, 1'b1, 9'h0EE);
        step(1'b0, 1'b0, '0);

        // R2/R4: drain across boundaries; R6: pull against empty
        cur_req = "R4";
        for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1, '0);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, '0);
        chk(empty_n == 1'b0, "R6", "empty after drain", int'(empty_n), 0);
        // R7: read and write together while empty, only the write lands
        cur_req = "R7";
        step(1'b1, 1'b1, 9'h055);
        step(1'b0, 1'b0, '0);
        chk(rd_data == 9'h055, "R7", "write lands when empty", int'(rd_data), 'h055);

        // R2/R11/R9: mixed traffic that wraps the ring many times
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            lfsr = nxt(lfsr);
            if (i < 1500) step(lfsr[3:0] < 10, lfsr[7:4] < 7, lfsr[16:8]);
            else          step(lfsr[3:0] < 6,  lfsr[7:4] < 10, lfsr[16:8]);
        end
        cur_req = "R9";
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, WIDTH'(i));
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, WIDTH'(i + 100));
        cur_req = "R11";
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, '0);

        // R1: reset in the middle of traffic
        cur_req = "R1";
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; rd_en = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(empty_n == 1'b0, "R1", "empty_n after mid reset", int'(empty_n), 0);
        chk(full_n == 1'b1, "R1", "full_n after mid reset", int'(full_n), 1);
        step(1'b1, 1'b0, 9'h0C3);
        step(1'b0, 1'b0, '0);
        chk(rd_data == 9'h0C3, "R1", "slice 0 writes after reset", int'(rd_data), 'h0C3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule